// File: doc/BRIEF.md
# TDM Quadrant Bit Replacement Unit

This unit sits on one deserialized time-division-multiplexed input stream and sees one channel byte per transfer, tagged with the channel's index within the frame and a flag marking the first channel of a frame. The frame of `N_CHAN` channels is divided into four equal quadrants. A 12-bit control word holds one 3-bit code per quadrant. Each code either lets the channel bytes of its quadrant through untouched, or pins the least or most significant bit of every byte in that quadrant to a chosen constant. The unit is used to insert fixed signalling or test patterns into whole regions of a frame.

Control words are written through a simple write strobe. They are staged and only take effect at the next accepted frame-start byte, so a frame never mixes two settings. A separate level input tells the unit that bit-error-rate reception is running on the same stream. That function cannot be combined with bit replacement, so the unit raises a conflict flag and passes data unmodified while both are on.

Both data sides use valid/ready handshakes. A byte moves on a side in any cycle where valid and ready are both high. The input is ready whenever the single output register is empty or is being drained in the same cycle. An output byte that is not accepted stays on the port unchanged until the downstream raises ready. Nothing is ever dropped or duplicated.

Top module: `qbr_unit`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, mode_conflict is 0, and both the staged and the in-force control words are zero, so data passes unchanged.
- R2: The code for quadrant q sits in control bits [3q+2:3q]: quadrant 3 in bits 11..9, 2 in 8..6, 1 in 5..3, 0 in 2..0. The quadrant of a byte is the top two bits of its channel index, so quadrant q covers channels q*N_CHAN/4 through (q+1)*N_CHAN/4-1.
- R3: A code whose top bit is 0 (0xx) leaves the byte unchanged.
- R4: Code 100 forces bit 0 (LSB) to 0, and code 101 forces bit 0 to 1.
- R5: Code 110 forces bit DATA_W-1 (MSB) to 0, and code 111 forces that bit to 1.
- R6: Every bit that the active code does not force is passed through exactly.
- R7: A control write takes effect on the next accepted byte with in_sof=1, and that byte already uses it. Bytes accepted earlier, including the rest of the current frame, keep the previous word.
- R8: mode_conflict is 1 exactly when ber_rx_en is 1 and the control word in force has at least one code with its top bit set. While in conflict, bytes pass unmodified.
- R9: A byte accepted in cycle t appears on out_valid/out_data in cycle t+1. in_ready is high when the output is empty or is being taken. A held output (out_valid=1, out_ready=0) keeps out_data stable.
- R10: Under any out_ready pattern, every accepted byte leaves exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 12 | Control word (four 3-bit quadrant codes) |
| ber_rx_en | input | 1 | BER reception active on this stream |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Unit can accept a byte |
| in_data | input | DATA_W | Input channel byte |
| in_chan | input | $clog2(N_CHAN) | Channel index of the input byte |
| in_sof | input | 1 | Input byte is channel 0 of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | DATA_W | Output channel byte |
| mode_conflict | output | 1 | Replacement and BER reception both enabled |

## Verification
The bench builds the unit with N_CHAN=16 and DATA_W=8. With these values each quadrant is four channels wide and a whole frame is only sixteen transfers. Every quadrant boundary, every code and every frame-start switch of settings can therefore be exercised many times within a short run. Byte patterns of all-ones, all-zeros and mixed values show both the forced bit and the preserved bits. A pseudo-random out_ready pattern keeps the output register both stalled and streaming while codes change frame by frame.

// File: rtl/qbr_pkg.sv
package qbr_pkg;
  localparam int QUADS   = 4;
  localparam int FIELD_W = 3;
  localparam int CFG_W   = QUADS * FIELD_W;

  typedef enum logic [1:0] {
    FORCE_LSB_LO = 2'b00,
    FORCE_LSB_HI = 2'b01,
    FORCE_MSB_LO = 2'b10,
    FORCE_MSB_HI = 2'b11
  } force_sel_e;

  typedef struct packed {
    logic       en;
    force_sel_e sel;
  } quad_code_t;

  // True when any quadrant code in the word requests a forced bit.
  function automatic logic cfg_has_force(input logic [CFG_W-1:0] cfg);
    logic hit;
    hit = 1'b0;
    for (int q = 0; q < QUADS; q++) begin
      hit = hit | cfg[q*FIELD_W + FIELD_W - 1];
    end
    return hit;
  endfunction
endpackage

// File: rtl/qbr_cfg_shadow.sv
module qbr_cfg_shadow
  import qbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_word,
  input  logic             frame_go,
  output logic [CFG_W-1:0] active_word,
  output logic [CFG_W-1:0] eff_word
);
  logic [CFG_W-1:0] staged_q;
  logic [CFG_W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      active_q <= '0;
    end else begin
      if (wr_en) staged_q <= wr_word;
      if (frame_go) active_q <= staged_q;
    end
  end

  // The frame-start byte itself already sees the staged word.
  assign eff_word    = frame_go ? staged_q : active_q;
  assign active_word = active_q;
endmodule

// File: rtl/qbr_quad_sel.sv
module qbr_quad_sel
  import qbr_pkg::*;
#(
  parameter int CHAN_W = 5
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [CHAN_W-1:0] chan,
  output quad_code_t        code
);
  localparam int QIDX_W = $clog2(QUADS);

  quad_code_t           fields [QUADS];
  logic [QIDX_W-1:0]    qidx;

  for (genvar g = 0; g < QUADS; g++) begin : g_field
    assign fields[g] = quad_code_t'(cfg[g*FIELD_W +: FIELD_W]);
  end

  assign qidx = chan[CHAN_W-1 -: QIDX_W];
  assign code = fields[qidx];
endmodule

// File: rtl/qbr_bit_force.sv
module qbr_bit_force
  import qbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data_in,
  input  quad_code_t        code,
  input  logic              bypass,
  output logic [DATA_W-1:0] data_out
);
  always_comb begin
    data_out = data_in;
    if (!bypass && code.en) begin
      unique case (code.sel)
        FORCE_LSB_LO: data_out[0]        = 1'b0;
        FORCE_LSB_HI: data_out[0]        = 1'b1;
        FORCE_MSB_LO: data_out[DATA_W-1] = 1'b0;
        FORCE_MSB_HI: data_out[DATA_W-1] = 1'b1;
        default:      data_out           = data_in;
      endcase
    end
  end
endmodule

// File: rtl/qbr_unit.sv
module qbr_unit
  import qbr_pkg::*;
#(
  parameter int N_CHAN = 32,
  parameter int DATA_W = 8,
  localparam int CHAN_W = $clog2(N_CHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              ber_rx_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CHAN_W-1:0] in_chan,
  input  logic              in_sof,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              mode_conflict
);
  logic              accept;
  logic              frame_go;
  logic [CFG_W-1:0]  active_cfg;
  logic [CFG_W-1:0]  eff_cfg;
  quad_code_t        cur_code;
  logic              suppress;
  logic [DATA_W-1:0] forced_data;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;

  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign frame_go = accept && in_sof;

  qbr_cfg_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_we),
    .wr_word    (cfg_wdata),
    .frame_go   (frame_go),
    .active_word(active_cfg),
    .eff_word   (eff_cfg)
  );

  qbr_quad_sel #(.CHAN_W(CHAN_W)) u_qsel (
    .cfg (eff_cfg),
    .chan(in_chan),
    .code(cur_code)
  );

  // Replacement is withheld for the whole word while BER reception runs.
  assign suppress = ber_rx_en && cfg_has_force(eff_cfg);

  qbr_bit_force #(.DATA_W(DATA_W)) u_force (
    .data_in (in_data),
    .code    (cur_code),
    .bypass  (suppress),
    .data_out(forced_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (accept) begin
      ov_q <= 1'b1;
      od_q <= forced_data;
    end else if (out_ready) begin
      ov_q <= 1'b0;
    end
  end

  assign out_valid     = ov_q;
  assign out_data      = od_q;
  assign mode_conflict = ber_rx_en && cfg_has_force(active_cfg);
endmodule

// File: rtl/qbr_unit_chk.sv
module qbr_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              mode_conflict,
  input logic [CFG_W-1:0]  active_cfg
);
  logic acc;
  assign acc = in_valid && in_ready;

  // R1: first cycle after reset release shows an empty output
  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  // R9: accepted byte is presented on the next cycle
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R9: a stalled output holds its byte
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: a taken byte with nothing new behind it leaves the output empty
  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !acc) |=> !out_valid);

  // R6: interior bits are never altered
  p_interior_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_data[DATA_W-2:1] == $past(in_data[DATA_W-2:1])));

  // R8: in conflict, mid-frame bytes pass through whole
  p_conflict_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sof && mode_conflict) |=> (out_data == $past(in_data)));

  // R7: the word in force changes only on an accepted frame start
  p_cfg_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_sof) |=> $stable(active_cfg));
endmodule

bind qbr_unit qbr_unit_chk #(.DATA_W(DATA_W), .CFG_W(qbr_pkg::CFG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .in_sof       (in_sof),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .mode_conflict(mode_conflict),
  .active_cfg   (active_cfg)
);

// File: tb/qbr_unit_bench.sv
`timescale 1ns/100ps
module qbr_unit_bench;
  localparam int NCH   = 16;
  localparam int DW    = 8;
  localparam int CW    = $clog2(NCH);
  localparam int QSIZE = NCH / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [11:0]   cfg_wdata = '0;
  logic          ber_rx_en = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_chan = '0;
  logic          in_sof = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic          mode_conflict;

  always #2 clk = ~clk;

  qbr_unit #(.N_CHAN(NCH), .DATA_W(DW)) u_qbr_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ber_rx_en(ber_rx_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_chan(in_chan), .in_sof(in_sof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mode_conflict(mode_conflict)
  );

  typedef struct {
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [11:0] m_staged = '0;
  logic [11:0] m_active = '0;
  logic        stall_mode = 1'b0;
  logic        hold = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Independent model of the requirements.
  function automatic logic [DW-1:0] model(input logic [DW-1:0] d, input int ch,
                                          input logic [11:0] cfg, input logic ber);
    int       q;
    logic [2:0] code;
    logic [DW-1:0] r;
    q = ch / QSIZE;
    code = cfg[3*q +: 3];
    r = d;
    if (ber && (cfg[2] || cfg[5] || cfg[8] || cfg[11])) return r;
    if (!code[2]) return r;
    case (code[1:0])
      2'b00: r[0] = 1'b0;
      2'b01: r[0] = 1'b1;
      2'b10: r[DW-1] = 1'b0;
      default: r[DW-1] = 1'b1;
    endcase
    return r;
  endfunction

  // Monitor: drives out_ready and pops the scoreboard on each transfer.
  always begin
    @(negedge clk);
    if (hold) out_ready = 1'b0;
    else if (stall_mode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[3];
    end else out_ready = 1'b1;
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) check(1'b0, "R10 unexpected output", out_data, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(out_data == e.d, e.tag, out_data, e.d);
      end
    end
  end

  task automatic write_cfg(input logic [11:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    m_staged = w;
  endtask

  task automatic send(input logic [DW-1:0] d, input int ch, input logic sof, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    in_chan = CW'(ch);
    in_sof = sof;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (sof) m_active = m_staged;
    e.d = model(d, ch, m_active, ber_rx_en);
    e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_sof = 1'b0;
  endtask

  task automatic send_frame(input logic [DW-1:0] seed, input string tag,
                            input int wr_at, input logic [11:0] wr_val);
    for (int ch = 0; ch < NCH; ch++) begin
      if (ch == wr_at) write_cfg(wr_val);
      send(seed ^ DW'(ch * 37), ch, ch == 0, tag);
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((sb.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    check(mode_conflict == 1'b0, "R1 mode_conflict after reset", mode_conflict, 0);

    // R1 R3: zero word passes; R7: mid-frame write does not touch this frame
    send_frame(8'h11, "R1 R3 R7 old word kept in frame", 6, 12'hFAC);
    // R2 R4 R5 R6: codes q0=100 q1=101 q2=110 q3=111
    send_frame(8'hA5, "R2 R4 R5 R6 code per quadrant", -1, 12'h000);
    send_frame(8'hFF, "R4 R6 all-ones bytes", -1, 12'h000);
    send_frame(8'h00, "R5 R6 all-zeros bytes", -1, 12'h000);

    // R10 under back-pressure with reversed codes q0=111 q1=110 q2=101 q3=100
    stall_mode = 1'b1;
    write_cfg(12'h977);
    send_frame(8'h5A, "R10 R2 reversed codes stalled", -1, 12'h000);
    send_frame(8'hC3, "R10 R6 stalled stream", 9, 12'h223);
    // R3: q0=011 and q2=000 pass, q1=100, q3=001 passes
    send_frame(8'h3C, "R3 mixed 0xx codes", -1, 12'h000);
    stall_mode = 1'b0;
    drain();

    // R8: BER reception with forcing word active
    ber_rx_en = 1'b1;
    @(negedge clk);
    #1;
    check(mode_conflict == 1'b1, "R8 conflict raised", mode_conflict, 1);
    send_frame(8'h96, "R8 data unmodified in conflict", -1, 12'h000);
    write_cfg(12'h6DB);
    send_frame(8'h69, "R8 R3 non-forcing word with ber", -1, 12'h000);
    drain();
    #1;
    check(mode_conflict == 1'b0, "R8 conflict cleared", mode_conflict, 0);
    ber_rx_en = 1'b0;

    // R9 latency: single byte with empty pipe and out_ready high
    write_cfg(12'hFAC);
    send(8'h42, 0, 1'b1, "R9 single byte");
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9 one-cycle latency", out_valid, 1);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 output empties", out_valid, 0);

    // R9 hold: stalled output stays put
    hold = 1'b1;
    send(8'h81, 12, 1'b0, "R9 held byte");
    @(negedge clk);
    #1;
    held = out_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b1, "R9 valid held", out_valid, 1);
      check(out_data == held, "R9 data stable", out_data, held);
      check(in_ready == 1'b0, "R9 not ready when full", in_ready, 0);
    end
    hold = 1'b0;
    drain();
    check(sb.size() == 0, "R10 scoreboard empty", sb.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule